// File: doc/BRIEF.md
# Dual-Section Latched Bus Transceiver

This block couples two buses, A and B, through a configurable number of byte-wide sections (two by default). Each section carries two independent paths, A-to-B and B-to-A. Each path has its own transparent latch and three active-low controls: chip enable, latch enable and output enable. The chip enable must be low for the latch to accept data and for the far-side port to drive. The latch enable chooses between following the input and holding a captured byte. The output enable chooses whether the far-side port drives at all.

Pads are modelled as plain vectors. Every output port is a data vector plus one enable bit per section. Every input bit comes with a driver-valid flag. A bus-hold keeper on each input bit remembers the last driven level and supplies it whenever the flag drops, so an undriven input never floats. Everything runs on one system clock. A control edge takes effect on the clock edge that samples it, and transparent data reaches the output in the same cycle. If a section is set to drive both of its ports at once, the block flags the contention.

Top module: `bt_xcvr`

## Requirements
- R1: Each section has its own six control inputs. A section's outputs depend only on its own controls, data and keepers, so sections can run apart or together as one wide path.
- R2: The B-to-A path follows R3 to R6 with the roles of the ports swapped. It uses the `ba_*` controls, takes data from the B inputs and drives the A outputs.
- R3: While `ab_ce_n` of a section is 1, that section's A-to-B latch keeps its contents whatever the latch and output enables do. In that state `b_oe` is 0 and that byte of `b_out` is 0.
- R4: The latch is open when chip enable and latch enable are both 0. While it is open and output enable is 0, the B byte equals the effective A byte in the same cycle, and the latch takes that byte at each clock edge.
- R5: The latch closes when latch enable rises or chip enable rises. From then on, the latch holds the effective input sampled at the last clock edge at which it was open. With chip enable 0 and output enable 0, the B byte shows that stored value and not the live input.
- R6: `b_oe` of a section is 1 exactly when its `ab_ce_n` and `ab_oe_n` are both 0. Whenever `b_oe` is 0, that byte of `b_out` is 0, and the latch keeps following or holding as R4 and R5 describe.
- R7: For each input bit, the effective value is the pin while its driver-valid flag is 1. Otherwise it is the pin's value at the last clock edge at which the flag was 1, or 0 if the flag has not been 1 since reset.
- R8: `clash` of a section is 1 exactly when that section's `a_oe` and `b_oe` are both 1.
- R9: While `rst_n` is 0, all latches and keepers clear to 0. After reset, a closed latch with its outputs enabled drives 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | NSEC*W | Levels seen on the A pins |
| a_vld | input | NSEC*W | Per-bit flag: an outside driver holds the A pin |
| b_in | input | NSEC*W | Levels seen on the B pins |
| b_vld | input | NSEC*W | Per-bit flag: an outside driver holds the B pin |
| ab_ce_n | input | NSEC | A-to-B chip enable per section, active low |
| ab_le_n | input | NSEC | A-to-B latch enable per section, active low |
| ab_oe_n | input | NSEC | A-to-B output enable per section, active low |
| ba_ce_n | input | NSEC | B-to-A chip enable per section, active low |
| ba_le_n | input | NSEC | B-to-A latch enable per section, active low |
| ba_oe_n | input | NSEC | B-to-A output enable per section, active low |
| a_out | output | NSEC*W | Data driven onto A (0 when not enabled) |
| a_oe | output | NSEC | A drive enable per section |
| b_out | output | NSEC*W | Data driven onto B (0 when not enabled) |
| b_oe | output | NSEC | B drive enable per section |
| clash | output | NSEC | Both ports of a section driven at once |

## Verification
The bench closes a latch at the moment its input changes, by raising latch enable and separately by raising chip enable. A design that stored one cycle late would show the new byte instead of the last open one. It holds chip enable high while the latch enable is low and the input moves. A latch gated by latch enable alone would pick up that data. It drops driver-valid flags in the middle of transparent flow, and a missing keeper would pass the raw pin through. It also drives both ports of one section while the other section stays idle. This shows whether the contention flag and the controls stay local to their own section.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // Active-low control triple for one direction of one section
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } bt_ctl_t;
endpackage

// File: rtl/bt_keeper.sv
module bt_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] pin_vld,
  output logic [W-1:0] eff
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic held;
    always_ff @(posedge clk) begin
      if (!rst_n)          held <= 1'b0;
      else if (pin_vld[i]) held <= pin[i];
    end
    assign eff[i] = pin_vld[i] ? pin[i] : held;

    AST_KEEPER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !pin_vld[i]) |-> (eff[i] == $past(eff[i]))); // R7
  end
endmodule

// File: rtl/bt_path.sv
module bt_path
  import bt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bt_ctl_t      ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         doe
);
  logic         open_g;
  logic [W-1:0] stored;
  logic [W-1:0] view;
  logic         armed;

  assign open_g = !ctl.ce_n && !ctl.le_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored <= '0;
      armed  <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (open_g) stored <= din;
    end
  end

  assign view = open_g ? din : stored;
  assign doe  = !ctl.ce_n && !ctl.oe_n;
  assign dout = doe ? view : '0;

  AST_CAPTURE_LAST_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !open_g && $past(open_g)) |-> (view == $past(din))); // R5
  AST_CLOSED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !open_g && $past(!open_g)) |-> $stable(view)); // R5
endmodule

// File: rtl/bt_section.sv
module bt_section
  import bt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_pin,
  input  logic [W-1:0] a_pin_vld,
  input  logic [W-1:0] b_pin,
  input  logic [W-1:0] b_pin_vld,
  input  bt_ctl_t      ab_ctl,
  input  bt_ctl_t      ba_ctl,
  output logic [W-1:0] a_dout,
  output logic         a_doe,
  output logic [W-1:0] b_dout,
  output logic         b_doe,
  output logic         clash
);
  logic [W-1:0] a_eff, b_eff;

  bt_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst_n(rst_n), .pin(a_pin), .pin_vld(a_pin_vld), .eff(a_eff)
  );
  bt_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst_n(rst_n), .pin(b_pin), .pin_vld(b_pin_vld), .eff(b_eff)
  );

  bt_path #(.W(W)) u_ab (
    .clk(clk), .rst_n(rst_n), .ctl(ab_ctl), .din(a_eff),
    .dout(b_dout), .doe(b_doe)
  );
  bt_path #(.W(W)) u_ba (
    .clk(clk), .rst_n(rst_n), .ctl(ba_ctl), .din(b_eff),
    .dout(a_dout), .doe(a_doe)
  );

  assign clash = a_doe && b_doe;

  AST_CLASH_NEEDS_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> (!ab_ctl.ce_n && !ab_ctl.oe_n && !ba_ctl.ce_n && !ba_ctl.oe_n)); // R8
  AST_CE_BLOCKS_B: assert property (@(posedge clk) disable iff (!rst_n)
    ab_ctl.ce_n |-> (!b_doe && (b_dout == '0))); // R3
  AST_CE_BLOCKS_A: assert property (@(posedge clk) disable iff (!rst_n)
    ba_ctl.ce_n |-> (!a_doe && (a_dout == '0))); // R2
endmodule

// File: rtl/bt_xcvr.sv
module bt_xcvr
  import bt_pkg::*;
#(
  parameter int W    = 8,
  parameter int NSEC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSEC*W-1:0] a_in,
  input  logic [NSEC*W-1:0] a_vld,
  input  logic [NSEC*W-1:0] b_in,
  input  logic [NSEC*W-1:0] b_vld,
  input  logic [NSEC-1:0]   ab_ce_n,
  input  logic [NSEC-1:0]   ab_le_n,
  input  logic [NSEC-1:0]   ab_oe_n,
  input  logic [NSEC-1:0]   ba_ce_n,
  input  logic [NSEC-1:0]   ba_le_n,
  input  logic [NSEC-1:0]   ba_oe_n,
  output logic [NSEC*W-1:0] a_out,
  output logic [NSEC-1:0]   a_oe,
  output logic [NSEC*W-1:0] b_out,
  output logic [NSEC-1:0]   b_oe,
  output logic [NSEC-1:0]   clash
);
  localparam int TOTW = NSEC * W;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    localparam int LO = s * W;
    bt_ctl_t ab_c, ba_c;
    assign ab_c = '{ce_n: ab_ce_n[s], le_n: ab_le_n[s], oe_n: ab_oe_n[s]};
    assign ba_c = '{ce_n: ba_ce_n[s], le_n: ba_le_n[s], oe_n: ba_oe_n[s]};

    bt_section #(.W(W)) u_sec (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_pin    (a_in[LO +: W]),
      .a_pin_vld(a_vld[LO +: W]),
      .b_pin    (b_in[LO +: W]),
      .b_pin_vld(b_vld[LO +: W]),
      .ab_ctl   (ab_c),
      .ba_ctl   (ba_c),
      .a_dout   (a_out[LO +: W]),
      .a_doe    (a_oe[s]),
      .b_dout   (b_out[LO +: W]),
      .b_doe    (b_oe[s]),
      .clash    (clash[s])
    );

    AST_OE_GATES_B: assert property (@(posedge clk) disable iff (!rst_n)
      ab_oe_n[s] |-> (!b_oe[s] && (b_out[LO +: W] == '0))); // R6
    AST_OE_GATES_A: assert property (@(posedge clk) disable iff (!rst_n)
      ba_oe_n[s] |-> (!a_oe[s] && (a_out[LO +: W] == '0))); // R6
  end

  AST_WIDTH_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe == '0) |-> (a_out == {TOTW{1'b0}})); // R6
endmodule

// File: tb/sim_bt_xcvr.sv
`timescale 1ns/1ps
module sim_bt_xcvr;
  localparam int W = 8;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS*W-1:0] a_in = '0, a_vld = '1, b_in = '0, b_vld = '1;
  logic [NS-1:0] ab_ce_n = '1, ab_le_n = '1, ab_oe_n = '1;
  logic [NS-1:0] ba_ce_n = '1, ba_le_n = '1, ba_oe_n = '1;
  logic [NS*W-1:0] a_out, b_out;
  logic [NS-1:0] a_oe, b_oe, clash;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [7:0] m_ka [NS];
  logic [7:0] m_kb [NS];
  logic [7:0] m_sab [NS];
  logic [7:0] m_sba [NS];

  always #4 clk = ~clk; // 125 MHz

  bt_xcvr #(.W(W), .NSEC(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_vld(a_vld), .b_in(b_in), .b_vld(b_vld),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe), .clash(clash)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] effv(input logic [7:0] p, input logic [7:0] v, input logic [7:0] k);
    return (p & v) | (k & ~v);
  endfunction

  function automatic string tag_for(input bit ce, input bit le, input bit oe, input bit kept_used);
    if (ce) return "R3";
    if (oe) return "R6";
    if (!le) return kept_used ? "R7" : "R4";
    return "R5";
  endfunction

  task automatic compare_all();
    for (int s = 0; s < NS; s++) begin
      logic [7:0] ea, eb, vb, va;
      bit ob, oa, eboe, eaoe;
      ea = effv(a_in[s*W +: W], a_vld[s*W +: W], m_ka[s]);
      eb = effv(b_in[s*W +: W], b_vld[s*W +: W], m_kb[s]);
      ob = !ab_ce_n[s] && !ab_le_n[s];
      oa = !ba_ce_n[s] && !ba_le_n[s];
      vb = ob ? ea : m_sab[s];
      va = oa ? eb : m_sba[s];
      eboe = !ab_ce_n[s] && !ab_oe_n[s];
      eaoe = !ba_ce_n[s] && !ba_oe_n[s];
      chk("R6", b_oe[s], eboe);
      chk(tag_for(ab_ce_n[s], ab_le_n[s], ab_oe_n[s], a_vld[s*W +: W] != 8'hFF),
          b_out[s*W +: W], eboe ? vb : 8'h00);
      chk("R2", a_oe[s], eaoe);
      chk("R2", a_out[s*W +: W], eaoe ? va : 8'h00);
      chk("R8", clash[s], eboe && eaoe);
    end
  endtask

  task automatic model_update();
    for (int s = 0; s < NS; s++) begin
      logic [7:0] ea, eb;
      ea = effv(a_in[s*W +: W], a_vld[s*W +: W], m_ka[s]);
      eb = effv(b_in[s*W +: W], b_vld[s*W +: W], m_kb[s]);
      if (!rst_n) begin
        m_ka[s] = '0; m_kb[s] = '0; m_sab[s] = '0; m_sba[s] = '0;
      end else begin
        if (!ab_ce_n[s] && !ab_le_n[s]) m_sab[s] = ea;
        if (!ba_ce_n[s] && !ba_le_n[s]) m_sba[s] = eb;
        m_ka[s] = ea;
        m_kb[s] = eb;
      end
    end
  endtask

  // every-cycle comparison against the reference
  initial begin
    for (int s = 0; s < NS; s++) begin
      m_ka[s] = '0; m_kb[s] = '0; m_sab[s] = '0; m_sba[s] = '0;
    end
    forever begin
      @(negedge clk);
      if (rst_n) compare_all();
      @(posedge clk);
      model_update();
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R9: closed latch, enabled, after reset drives zero
    ab_ce_n[0] = 0; ab_le_n[0] = 1; ab_oe_n[0] = 0;
    ba_ce_n[0] = 0; ba_le_n[0] = 1; ba_oe_n[0] = 0;
    a_in[7:0] = 8'hE1; b_in[7:0] = 8'hE2;
    at_neg();
    chk("R9", b_out[7:0], 8'h00);
    chk("R9", a_out[7:0], 8'h00);
    chk("R9", b_oe[0], 1'b1);
    ba_ce_n[0] = 1;
    tick();
    // R4: transparent, same-cycle follow
    ab_le_n[0] = 0; a_in[7:0] = 8'h5A;
    at_neg();
    chk("R4", b_out[7:0], 8'h5A);
    a_in[7:0] = 8'h3C;
    #1 chk("R4", b_out[7:0], 8'h3C);
    tick();
    // R5: latch enable rises as data changes; stored is last open byte
    ab_le_n[0] = 1; a_in[7:0] = 8'h77;
    at_neg();
    chk("R5", b_out[7:0], 8'h3C);
    tick(2);
    chk("R5", b_out[7:0], 8'h3C);
    // R5: closing by chip enable rise
    ab_le_n[0] = 0; a_in[7:0] = 8'h11;
    tick();
    ab_ce_n[0] = 1; a_in[7:0] = 8'h22;
    at_neg();
    chk("R3", b_oe[0], 1'b0);
    chk("R3", b_out[7:0], 8'h00);
    tick();
    ab_ce_n[0] = 0; ab_le_n[0] = 1;
    at_neg();
    chk("R5", b_out[7:0], 8'h11);
    tick();
    // R6: output enable high blocks drive, latch still follows
    ab_oe_n[0] = 1; ab_le_n[0] = 0; a_in[7:0] = 8'h44;
    at_neg();
    chk("R6", b_oe[0], 1'b0);
    chk("R6", b_out[7:0], 8'h00);
    tick();
    ab_le_n[0] = 1; ab_oe_n[0] = 0; a_in[7:0] = 8'h00;
    at_neg();
    chk("R6", b_out[7:0], 8'h44);
    tick();
    // R3: chip enable high with latch enable low must not load
    ab_ce_n[0] = 1; ab_le_n[0] = 0; a_in[7:0] = 8'h99;
    tick(2);
    ab_ce_n[0] = 0; ab_le_n[0] = 1;
    at_neg();
    chk("R3", b_out[7:0], 8'h44);
    tick();
    // R1: section 1 transparent while section 0 holds
    ab_ce_n[1] = 0; ab_le_n[1] = 0; ab_oe_n[1] = 0; a_in[15:8] = 8'hC3;
    at_neg();
    chk("R1", b_out[15:8], 8'hC3);
    chk("R1", b_out[7:0], 8'h44);
    tick();
    // R2: B-to-A transparent on section 0
    ba_ce_n[0] = 0; ba_le_n[0] = 0; ba_oe_n[0] = 1; b_in[7:0] = 8'hA5;
    tick();
    ba_le_n[0] = 1; ba_oe_n[0] = 0; b_in[7:0] = 8'h0F;
    at_neg();
    chk("R2", a_out[7:0], 8'hA5);
    tick();
    // R7: keeper supplies last driven level
    ab_le_n[0] = 0; a_vld[7:0] = 8'hFF; a_in[7:0] = 8'h12;
    tick();
    a_vld[7:0] = 8'h0F; a_in[7:0] = 8'hFF;
    at_neg();
    chk("R7", b_out[7:0], 8'h1F);
    tick();
    a_vld[7:0] = 8'h00; a_in[7:0] = 8'h00;
    at_neg();
    chk("R7", b_out[7:0], 8'h1F);
    tick();
    a_vld[7:0] = 8'hFF;
    // R8: section 1 drives both ports, section 0 only A
    ab_oe_n[0] = 1;
    ba_ce_n[1] = 0; ba_oe_n[1] = 0;
    at_neg();
    chk("R8", clash[1], 1'b1);
    chk("R8", clash[0], 1'b0);
    tick();
    // random soak, reference compared every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      {ab_ce_n, ab_le_n, ab_oe_n} = r[5:0];
      {ba_ce_n, ba_le_n, ba_oe_n} = r[11:6];
      a_in = $urandom; b_in = $urandom;
      a_vld = (r[12]) ? 16'hFFFF : 16'($urandom);
      b_vld = (r[13]) ? 16'hFFFF : 16'($urandom);
      tick();
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule